// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block sits between a simple 8-bit processor core and an external bus on which the low address byte and the data byte share one set of pins. The core asks for one bus cycle at a time: an opcode fetch, a memory read, a memory write, an I/O read or an I/O write. Each request carries a 16-bit address, a write byte for write cycles and, for opcode fetches, the number of extra internal T-states the core needs. The sequencer then steps through the T-states of that cycle, one per clock. It drives the upper address byte, the shared pins with their output enable, the address latch pulse, the memory/IO select and the two status lines, and the active-low read and write strobes.

For read-type cycles the byte on the shared pins is captured and returned to the core with a one-clock done strobe in the final T-state. A new request may be presented in that same final T-state, so cycles can follow each other with no idle clock between them. The shared pins are modelled as a separate input, output and output-enable, so the tri-state buffer stays outside the block.

Top module: `mux_bus_seq`

## Requirements
- R1: In T1 the latch pulse `ale` is high for exactly one clock, both strobes are high, `ad_oe` is 1 and `ad_out` carries address bits 7:0. `a_hi` carries address bits 15:8 for memory-type cycles, and the port byte (address bits 7:0) for I/O cycles.
- R2: The request kind is encoded on `req_kind` as 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. From T1 to the last T-state, {`io_m`,`s1`,`s0`} is held at 011 for a fetch, 010 for a memory read, 001 for a memory write, 110 for an I/O read and 101 for an I/O write.
- R3: In T2 `ale` is low. `rd_n` is low in T2 only, and only for fetch, memory read and I/O read. `wr_n` is low in T2 and T3, and only for memory write and I/O write.
- R4: In a read-type cycle `ad_oe` is 0 from T2 onward. The byte on `ad_in` at the clock edge that ends T2 is captured into `rdata`, and in T3 `rd_n` is already back high.
- R5: In a write cycle `ad_out` carries the write byte with `ad_oe` = 1 during T2 and T3. Both `wr_n` and `ad_oe` return to their inactive values after T3.
- R6: `rd_n` and `wr_n` are never low at the same time.
- R7: Non-fetch cycles last three T-states. A fetch lasts 4 + `req_extra` T-states, and values of `req_extra` above 2 are treated as 2. In T4 and later T-states both strobes are high and `ad_oe` is 0.
- R8: `done` is high for exactly one clock, in the last T-state of each cycle, and `rdata` holds the captured byte while `done` is high.
- R9: `req_ready` is high when the sequencer is idle or in a last T-state. A request made while `req_ready` is low is ignored, and a request accepted in a last T-state begins its T1 on the very next clock.
- R10: A request whose `req_kind` is 5, 6 or 7 is ignored, and the sequencer stays idle.
- R11: When idle, `rd_n` and `wr_n` are 1, `ale` is 0, `ad_oe` is 0 and {`io_m`,`s1`,`s0`} is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Bus cycle kind |
| req_addr | input | 16 | Memory address or port number (bits 7:0) |
| req_wdata | input | 8 | Byte to write |
| req_extra | input | 2 | Extra T-states beyond T4 for a fetch |
| req_ready | output | 1 | Request can be accepted this clock |
| done | output | 1 | Last T-state of the cycle |
| rdata | output | 8 | Captured read byte |
| a_hi | output | 8 | Upper address bus |
| ad_out | output | 8 | Shared pins, outgoing value |
| ad_oe | output | 1 | Shared pins output enable |
| ad_in | input | 8 | Shared pins, incoming value |
| ale | output | 1 | Address latch pulse |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data path and at most two extra fetch T-states. With these values every fetch length (four, five and six T-states) can be reached, and so can the clamping of an oversized extra count. Fetches chained straight onto writes and reads show that a new T1 follows a last T-state with no gap. Requests made in the middle of a cycle, and requests with undefined kind codes, probe the acceptance rules at the ports.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } cyc_kind_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } bus_status_t;

  function automatic logic kind_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic kind_reads(input cyc_kind_e k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic kind_writes(input cyc_kind_e k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic kind_io(input cyc_kind_e k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  function automatic bus_status_t status_of(input cyc_kind_e k);
    bus_status_t st;
    case (k)
      K_FETCH: st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      K_MRD:   st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      K_MWR:   st = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      K_IORD:  st = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      K_IOWR:  st = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
      default: st = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};
    endcase
    return st;
  endfunction

endpackage

// File: rtl/mbs_reset_sync.sv
module mbs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/mbs_tstate_ctrl.sv
module mbs_tstate_ctrl
  import mbs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int EXTRA_W   = 2,
  parameter int EXTRA_MAX = 2,
  parameter int ST_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [EXTRA_W-1:0] req_extra,
  output logic [ST_W-1:0]   tstate,
  output cyc_kind_e         kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              at_last
);

  localparam logic [ST_W-1:0] T_IDLE   = '0;
  localparam logic [ST_W-1:0] T_ONE    = ST_W'(1);
  localparam logic [ST_W-1:0] T_BASE   = ST_W'(3);
  localparam int              FETCH_T4 = 4;

  logic [ST_W-1:0]   tstate_q, tstate_d;
  logic [ST_W-1:0]   last_q, last_d;
  cyc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;
  int                extra_i;

  // next-state process
  always_comb begin
    at_last = (tstate_q != T_IDLE) && (tstate_q == last_q);
    ready   = (tstate_q == T_IDLE) || at_last;
    accept  = req_valid && ready && kind_ok(req_kind);

    extra_i = int'(req_extra);
    if (extra_i > EXTRA_MAX) extra_i = EXTRA_MAX;

    if (cyc_kind_e'(req_kind) == K_FETCH) last_d = ST_W'(FETCH_T4 + extra_i);
    else                                   last_d = T_BASE;

    tstate_d = tstate_q;
    if (accept)                    tstate_d = T_ONE;
    else if (at_last)              tstate_d = T_IDLE;
    else if (tstate_q != T_IDLE)   tstate_d = tstate_q + T_ONE;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tstate_q <= T_IDLE;
      last_q   <= T_BASE;
      kind_q   <= K_FETCH;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      tstate_q <= tstate_d;
      if (accept) begin
        last_q  <= last_d;
        kind_q  <= cyc_kind_e'(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign tstate = tstate_q;
  assign kind   = kind_q;
  assign addr   = addr_q;
  assign wdata  = wdata_q;

endmodule

// File: rtl/mbs_bus_drive.sv
module mbs_bus_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ST_W   = 3
) (
  input  logic [ST_W-1:0]          tstate,
  input  cyc_kind_e                kind,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     ale,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic                     rd_n,
  output logic                     wr_n
);

  localparam int              HI_W = ADDR_W - DATA_W;
  localparam logic [ST_W-1:0] T_1  = ST_W'(1);
  localparam logic [ST_W-1:0] T_2  = ST_W'(2);
  localparam logic [ST_W-1:0] T_3  = ST_W'(3);

  bus_status_t st;

  always_comb begin
    a_hi   = '0;
    ad_out = '0;
    ad_oe  = 1'b0;
    ale    = 1'b0;
    io_m   = 1'b0;
    s1     = 1'b0;
    s0     = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    st     = status_of(kind);

    if (tstate != '0) begin
      io_m = st.io_m;
      s1   = st.s1;
      s0   = st.s0;
      if (kind_io(kind)) a_hi = HI_W'(addr[DATA_W-1:0]);
      else               a_hi = addr[ADDR_W-1:DATA_W];

      if (tstate == T_1) begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        ad_out = addr[DATA_W-1:0];
      end else if (tstate == T_2) begin
        if (kind_reads(kind)) rd_n = 1'b0;
        if (kind_writes(kind)) begin
          wr_n   = 1'b0;
          ad_oe  = 1'b1;
          ad_out = wdata;
        end
      end else if (tstate == T_3) begin
        if (kind_writes(kind)) begin
          wr_n   = 1'b0;
          ad_oe  = 1'b1;
          ad_out = wdata;
        end
      end
    end
  end

endmodule

// File: rtl/mbs_rd_capture.sv
module mbs_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] byte_q, byte_d;

  always_comb begin
    byte_d = byte_q;
    if (cap_en) byte_d = ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_q <= '0;
    else        byte_q <= byte_d;
  end

  assign rdata = byte_q;

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int EXTRA_W   = 2,
  parameter int EXTRA_MAX = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [EXTRA_W-1:0]       req_extra,
  output logic                     req_ready,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic                     rd_n,
  output logic                     wr_n
);

  localparam int              ST_W    = $clog2(4 + EXTRA_MAX + 1);
  localparam logic [ST_W-1:0] T_CAP   = ST_W'(2);

  logic              rst_n_int;
  logic [ST_W-1:0]   tstate;
  cyc_kind_e         kind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic              at_last;
  logic              cap_en;

  mbs_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  mbs_tstate_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXTRA_W(EXTRA_W),
    .EXTRA_MAX(EXTRA_MAX), .ST_W(ST_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_extra (req_extra),
    .tstate    (tstate),
    .kind      (kind),
    .addr      (addr),
    .wdata     (wdata),
    .ready     (req_ready),
    .at_last   (at_last)
  );

  mbs_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ST_W(ST_W)) u_drive (
    .tstate (tstate),
    .kind   (kind),
    .addr   (addr),
    .wdata  (wdata),
    .a_hi   (a_hi),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .ale    (ale),
    .io_m   (io_m),
    .s1     (s1),
    .s0     (s0),
    .rd_n   (rd_n),
    .wr_n   (wr_n)
  );

  assign cap_en = (tstate == T_CAP) && kind_reads(kind);

  mbs_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .cap_en (cap_en),
    .ad_in  (ad_in),
    .rdata  (rdata)
  );

  assign done = at_last;

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic ad_oe,
  input logic ale,
  input logic io_m,
  input logic s1,
  input logic s0,
  input logic rd_n,
  input logic wr_n
);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_ale_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_t1_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && ad_oe));

  assert_t2_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!rd_n || !wr_n));

  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_status_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !req_ready) |-> $stable({io_m, s1, s0}));

endmodule

bind mux_bus_seq mbs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .ad_oe     (ad_oe),
  .ale       (ale),
  .io_m      (io_m),
  .s1        (s1),
  .s0        (s0),
  .rd_n      (rd_n),
  .wr_n      (wr_n)
);

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic [1:0]  req_extra;
  logic        req_ready;
  logic        done;
  logic [7:0]  rdata;
  logic [7:0]  a_hi;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic        ale;
  logic        io_m;
  logic        s1;
  logic        s0;
  logic        rd_n;
  logic        wr_n;

  int checks = 0;
  int fails  = 0;
  bit running = 0;

  typedef struct {
    bit         is_rd;
    logic [7:0] val;
  } sb_item_t;
  sb_item_t sb_q[$];

  mux_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_extra(req_extra),
    .req_ready(req_ready), .done(done), .rdata(rdata), .a_hi(a_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .io_m(io_m),
    .s1(s1), .s0(s0), .rd_n(rd_n), .wr_n(wr_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string where);
    chk(rd_n && wr_n && !ale && !ad_oe, {"R11 idle strobes ", where},
        {rd_n, wr_n, ale, ad_oe}, 4'b1100);
    chk({io_m, s1, s0} == 3'b000, {"R11 idle status ", where}, {io_m, s1, s0}, 3'b000);
    chk(req_ready == 1'b1, {"R9 ready idle ", where}, req_ready, 1);
  endtask

  // Driver: called just after a negedge, returns at the negedge inside the last T-state.
  task automatic run_cyc(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                         input logic [1:0] ex, input logic [7:0] rb, input bit noise);
    bit rdk = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    bit wrk = (k == 3'd2) || (k == 3'd4);
    bit iok = (k == 3'd3) || (k == 3'd4);
    bit fet = (k == 3'd0);
    logic [2:0] st_exp;
    int n_t;
    sb_item_t it;
    st_exp = fet ? 3'b011 : (k == 3'd1) ? 3'b010 : (k == 3'd2) ? 3'b001 :
             (k == 3'd3) ? 3'b110 : 3'b101;
    n_t = fet ? 4 + ((ex > 2'd2) ? 2 : int'(ex)) : 3;

    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; req_extra = ex;
    it.is_rd = rdk; it.val = rb;
    sb_q.push_back(it);

    @(negedge clk);  // T1
    req_valid = 1'b0;
    chk(ale == 1'b1, "R1 ale in T1", ale, 1);
    chk(ad_oe == 1'b1 && ad_out == a[7:0], "R1 low address on AD", {ad_oe, ad_out}, {1'b1, a[7:0]});
    chk(a_hi == (iok ? a[7:0] : a[15:8]), "R1 high address bus", a_hi, iok ? a[7:0] : a[15:8]);
    chk(rd_n && wr_n, "R1 no strobe in T1", {rd_n, wr_n}, 2'b11);
    chk({io_m, s1, s0} == st_exp, "R2 status in T1", {io_m, s1, s0}, st_exp);
    chk(req_ready == 1'b0, "R9 busy in T1", req_ready, 0);
    if (noise) begin
      req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'hDEAD; req_wdata = 8'h77;
    end

    @(negedge clk);  // T2
    req_valid = 1'b0;
    chk(ale == 1'b0, "R3 ale low in T2", ale, 0);
    chk(rd_n == !rdk && wr_n == !wrk, "R3 strobes in T2", {rd_n, wr_n}, {!rdk, !wrk});
    chk(ad_oe == wrk, "R4/R5 AD direction in T2", ad_oe, wrk);
    if (wrk) chk(ad_out == wd, "R5 write byte in T2", ad_out, wd);
    chk({io_m, s1, s0} == st_exp, "R2 status in T2", {io_m, s1, s0}, st_exp);
    ad_in = rb;

    @(negedge clk);  // T3
    ad_in = ~rb;
    chk(rd_n == 1'b1, "R4 rd_n high in T3", rd_n, 1);
    chk(wr_n == !wrk && ad_oe == wrk, "R5 write held in T3", {wr_n, ad_oe}, {!wrk, wrk});
    if (wrk) chk(ad_out == wd, "R5 write byte in T3", ad_out, wd);
    if (rdk) chk(rdata == rb, "R4 captured byte", rdata, rb);
    chk(done == !fet, "R7 done in T3", done, !fet);
    chk({io_m, s1, s0} == st_exp, "R2 status in T3", {io_m, s1, s0}, st_exp);

    for (int t = 4; t <= n_t; t++) begin
      @(negedge clk);
      chk(rd_n && wr_n && !ad_oe && !ale, "R7 internal T-state quiet", {rd_n, wr_n, ad_oe, ale}, 4'b1100);
      chk({io_m, s1, s0} == 3'b011, "R2 fetch status held", {io_m, s1, s0}, 3'b011);
      chk(done == (t == n_t), "R7 fetch length", done, t == n_t);
    end
  endtask

  // Monitor: scoreboard pops one item per done pulse.
  always @(negedge clk) begin
    if (running) begin
      chk(!(!rd_n && !wr_n), "R6 strobe exclusion", {rd_n, wr_n}, 2'b11);
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8 done without request", 1, 0);
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          if (it.is_rd) chk(rdata == it.val, "R8 rdata with done", rdata, it.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = '0;
    req_wdata = '0; req_extra = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 no done after reset", done, 0);
    chk_idle("after reset");
    running = 1;

    run_cyc(3'd1, 16'h1234, 8'h00, 2'd0, 8'hA5, 0);   // memory read
    @(negedge clk);
    chk_idle("after read");
    chk(done == 1'b0, "R8 done single clock", done, 0);

    run_cyc(3'd2, 16'h8001, 8'h3C, 2'd0, 8'h00, 0);   // memory write
    run_cyc(3'd0, 16'h0100, 8'h00, 2'd0, 8'h3E, 0);   // chained fetch, 4 T
    run_cyc(3'd0, 16'h0101, 8'h00, 2'd1, 8'hC9, 0);   // fetch, 5 T
    run_cyc(3'd0, 16'h0102, 8'h00, 2'd2, 8'h81, 0);   // fetch, 6 T
    run_cyc(3'd0, 16'h0103, 8'h00, 2'd3, 8'h5B, 0);   // clamp to 6 T (R7)
    @(negedge clk);
    chk_idle("after fetches");

    run_cyc(3'd3, 16'h0047, 8'h00, 2'd0, 8'h5A, 0);   // I/O read
    run_cyc(3'd4, 16'h0099, 8'hC3, 2'd0, 8'h00, 1);   // I/O write, mid-cycle request ignored (R9)
    @(negedge clk);
    chk_idle("after busy request");

    // R10: undefined kinds ignored
    for (int code = 5; code <= 7; code++) begin
      req_valid = 1'b1; req_kind = 3'(code); req_addr = 16'h4444;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!ale && rd_n && wr_n && !ad_oe, "R10 undefined kind stays idle",
          {ale, rd_n, wr_n, ad_oe}, 4'b0110);
      @(negedge clk);
      chk(!done && req_ready, "R10 no cycle started", {done, req_ready}, 2'b01);
    end

    run_cyc(3'd1, 16'hFFFF, 8'h00, 2'd0, 8'hFF, 0);
    run_cyc(3'd1, 16'h0000, 8'h00, 2'd0, 8'h00, 0);
    @(negedge clk);
    chk_idle("end");
    chk(sb_q.size() == 0, "R8 every request completed", sb_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule